// File: doc/BRIEF.md
# PWM/PFM Mode Transition Controller

This block chooses, for each converter channel, between fixed-frequency pulse-width operation and light-load pulse-frequency operation. Once per switching cycle a strobe delivers a signed measured-current sample for that channel. The block compares the sample with a programmable current threshold. It counts how many strobed samples in a row fall below that threshold. When the run reaches a programmable length, the channel enters PFM. The usual setting for the run length is 20 cycles.

While a channel is in PFM, it returns to PWM at once if a single sample is at or above the threshold, or if the regulation loop requests an exit. A per-channel PFM permit and a per-channel enable both hold the channel in PWM and discard any partial run. The registered mode flag feeds the modulator and the loop selector. All channels share one clock and are fully independent of each other.

Top module: `pwm_pfm_sel`

## Requirements
- R1: After reset, every `pfm_mode_o` bit is 0 (PWM), and every channel's run count is zero.
- R2: Each strobed sample that is strictly below the threshold extends the run by one. The mode flag goes to 1 on the clock edge that captures the `run_len_i`-th consecutive below-threshold strobe.
- R3: A strobed sample at or above the threshold, including a sample equal to it, sets the run back to zero.
- R4: The sample and the threshold are two's complement numbers, and they are compared as signed values.
- R5: In PFM, a strobed sample at or above the threshold sets the flag to 0 on the edge that captures it.
- R6: `exit_req_i` high sets the flag to 0 on the next edge, with or without a strobe, and clears the run.
- R7: `pfm_allow_i` low keeps the channel in PWM and clears the run.
- R8: `chan_en_i` low keeps the channel in PWM and clears the run.
- R9: In a cycle without a strobe, the sample value is ignored, and both the mode and the run count hold.
- R10: A `run_len_i` value of 0 or 1 enters PFM on the first below-threshold strobe.
- R11: Channels are independent. Channel c uses bits [c] of the 1-bit vectors, bits [c*SAMPLE_W +: SAMPLE_W] of `sample_i` and `thresh_i`, and bits [c*CNT_W +: CNT_W] of `run_len_i`.
- R12: Entering PFM clears the run. After the channel returns to PWM, a full new run is needed to enter PFM again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_en_i | input | NUM_CH | Channel enable |
| pfm_allow_i | input | NUM_CH | PFM permitted |
| sample_vld_i | input | NUM_CH | Per-cycle sample strobe |
| sample_i | input | NUM_CH*SAMPLE_W | Signed current samples |
| thresh_i | input | NUM_CH*SAMPLE_W | Signed PFM current thresholds |
| run_len_i | input | NUM_CH*CNT_W | Consecutive-cycle count for entry |
| exit_req_i | input | NUM_CH | Loop-requested PFM exit |
| pfm_mode_o | output | NUM_CH | 1 = PFM, 0 = PWM |

## Verification
A vector walk on one channel covers several sample patterns:
- Runs broken by a sample equal to the threshold, which separates a less-than compare from a less-or-equal compare.
- Runs interrupted by cycles without a strobe but with large samples, which shows that the count holds rather than resets.
- A PFM stay broken by an above-threshold sample.
- Re-entry after a loop exit, which shows whether the run was cleared.

Directed patterns then cover the following cases:
- A 20-cycle run, checked one strobe short of entry and again at entry.
- Negative thresholds, which separate a signed compare from an unsigned one.
- Disabling or forbidding PFM part-way through a run.
- Run lengths of 0 and 1.
- Traffic on one channel only, which exposes any cross-channel coupling.

// File: rtl/pwm_pfm_pkg.sv
package pwm_pfm_pkg;
  typedef enum logic {MODE_PWM = 1'b0, MODE_PFM = 1'b1} mode_e;
endpackage

// File: rtl/pwm_pfm_cmp.sv
module pwm_pfm_cmp #(
  parameter int SAMPLE_W = 12
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] thresh_i,
  output logic                below_o
);
  assign below_o = $signed(sample_i) < $signed(thresh_i);
endmodule

// File: rtl/pwm_pfm_run_cnt.sv
module pwm_pfm_run_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] run_len_i,
  output logic             hit_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + EXT_W'(1);
  // run_len 0 behaves like 1
  assign hit_o   = inc_i && (cnt_nxt >= {1'b0, run_len_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || hit_o) cnt_q <= '0;
    else if (inc_i)          cnt_q <= cnt_nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/pwm_pfm_chan.sv
module pwm_pfm_chan
  import pwm_pfm_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int CNT_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                allow_i,
  input  logic                vld_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] thresh_i,
  input  logic [CNT_W-1:0]    run_len_i,
  input  logic                exit_i,
  output logic                pfm_o
);
  mode_e mode_q, mode_d;
  logic  below, active, inc, clr, hit;

  pwm_pfm_cmp #(.SAMPLE_W(SAMPLE_W)) i_cmp (
    .sample_i(sample_i),
    .thresh_i(thresh_i),
    .below_o (below)
  );

  assign active = en_i && allow_i;
  assign inc    = active && !exit_i && vld_i && below && (mode_q == MODE_PWM);
  assign clr    = !active || exit_i || (vld_i && !below) || (mode_q == MODE_PFM);

  pwm_pfm_run_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .inc_i    (inc),
    .run_len_i(run_len_i),
    .hit_o    (hit)
  );

  always_comb begin
    mode_d = mode_q;
    if (!active || exit_i)                          mode_d = MODE_PWM;
    else if (mode_q == MODE_PFM && vld_i && !below) mode_d = MODE_PWM;
    else if (hit)                                   mode_d = MODE_PFM;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_PWM;
    else         mode_q <= mode_d;
  end

  assign pfm_o = (mode_q == MODE_PFM);
endmodule

// File: rtl/pwm_pfm_sel.sv
module pwm_pfm_sel #(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 12,
  parameter int CNT_W    = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CH-1:0]          chan_en_i,
  input  logic [NUM_CH-1:0]          pfm_allow_i,
  input  logic [NUM_CH-1:0]          sample_vld_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] sample_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] thresh_i,
  input  logic [NUM_CH*CNT_W-1:0]    run_len_i,
  input  logic [NUM_CH-1:0]          exit_req_i,
  output logic [NUM_CH-1:0]          pfm_mode_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_pfm_chan #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) i_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (chan_en_i[c]),
      .allow_i  (pfm_allow_i[c]),
      .vld_i    (sample_vld_i[c]),
      .sample_i (sample_i[c*SAMPLE_W +: SAMPLE_W]),
      .thresh_i (thresh_i[c*SAMPLE_W +: SAMPLE_W]),
      .run_len_i(run_len_i[c*CNT_W +: CNT_W]),
      .exit_i   (exit_req_i[c]),
      .pfm_o    (pfm_mode_o[c])
    );
  end
endmodule

// File: rtl/pwm_pfm_sel_chk.sv
module pwm_pfm_sel_chk #(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 12,
  parameter int CNT_W    = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_CH-1:0]          chan_en_i,
  input logic [NUM_CH-1:0]          pfm_allow_i,
  input logic [NUM_CH-1:0]          sample_vld_i,
  input logic [NUM_CH*SAMPLE_W-1:0] sample_i,
  input logic [NUM_CH*SAMPLE_W-1:0] thresh_i,
  input logic [NUM_CH*CNT_W-1:0]    run_len_i,
  input logic [NUM_CH-1:0]          exit_req_i,
  input logic [NUM_CH-1:0]          pfm_mode_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    logic at_or_above;
    assign at_or_above = $signed(sample_i[c*SAMPLE_W +: SAMPLE_W]) >=
                         $signed(thresh_i[c*SAMPLE_W +: SAMPLE_W]);

    a_r8_disable_pwm: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !chan_en_i[c] |=> !pfm_mode_o[c]);

    a_r7_forbid_pwm: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pfm_allow_i[c] |=> !pfm_mode_o[c]);

    a_r6_exit_pwm: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exit_req_i[c] |=> !pfm_mode_o[c]);

    a_r5_above_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sample_vld_i[c] && at_or_above) |=> !pfm_mode_o[c]);

    a_r2_entry_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pfm_mode_o[c]) |-> $past(sample_vld_i[c]) && !$past(at_or_above));

    a_r9_hold_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (chan_en_i[c] && pfm_allow_i[c] && !sample_vld_i[c] && !exit_req_i[c])
        |=> $stable(pfm_mode_o[c]));
  end
endmodule

bind pwm_pfm_sel pwm_pfm_sel_chk #(
  .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)
) i_pwm_pfm_sel_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .chan_en_i   (chan_en_i),
  .pfm_allow_i (pfm_allow_i),
  .sample_vld_i(sample_vld_i),
  .sample_i    (sample_i),
  .thresh_i    (thresh_i),
  .run_len_i   (run_len_i),
  .exit_req_i  (exit_req_i),
  .pfm_mode_o  (pfm_mode_o)
);

// File: tb/test_pwm_pfm_sel.sv
module test_pwm_pfm_sel;
  localparam int NUM_CH = 2;
  localparam int SW     = 12;
  localparam int CW     = 8;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [NUM_CH-1:0]    chan_en_i = '1;
  logic [NUM_CH-1:0]    pfm_allow_i = '1;
  logic [NUM_CH-1:0]    sample_vld_i = '0;
  logic [NUM_CH*SW-1:0] sample_i = '0;
  logic [NUM_CH*SW-1:0] thresh_i = '0;
  logic [NUM_CH*CW-1:0] run_len_i = '0;
  logic [NUM_CH-1:0]    exit_req_i = '0;
  logic [NUM_CH-1:0]    pfm_mode_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  pwm_pfm_sel #(.NUM_CH(NUM_CH), .SAMPLE_W(SW), .CNT_W(CW)) i_pwm_pfm_sel (.*);

  typedef struct packed {
    logic                 vld;
    logic signed [SW-1:0] smp;
    logic                 ex;
    logic                 exp;
  } vec_t;

  // channel 0, threshold 100, run length 3
  localparam vec_t VECS [17] = '{
    '{1'b1, 12'sd50,  1'b0, 1'b0},  // R2 run 1
    '{1'b1, 12'sd60,  1'b0, 1'b0},  // R2 run 2
    '{1'b1, 12'sd100, 1'b0, 1'b0},  // R3 equal resets
    '{1'b1, 12'sd10,  1'b0, 1'b0},
    '{1'b0, 12'sd10,  1'b0, 1'b0},  // R9 no strobe holds count
    '{1'b1, 12'sd20,  1'b0, 1'b0},
    '{1'b1, 12'sd30,  1'b0, 1'b1},  // R2 entry
    '{1'b1, 12'sd99,  1'b0, 1'b1},
    '{1'b0, 12'sd500, 1'b0, 1'b1},  // R9 ignored sample
    '{1'b1, 12'sd100, 1'b0, 1'b0},  // R5 exit on equal
    '{1'b1, 12'sd1,   1'b0, 1'b0},  // R12 fresh run
    '{1'b1, 12'sd1,   1'b0, 1'b0},
    '{1'b0, 12'sd1,   1'b1, 1'b0},  // R6 exit req clears run
    '{1'b1, 12'sd1,   1'b0, 1'b0},
    '{1'b1, 12'sd1,   1'b0, 1'b0},
    '{1'b1, 12'sd1,   1'b0, 1'b1},
    '{1'b0, 12'sd1,   1'b1, 1'b0}   // R6 exit from PFM
  };

  task automatic check(input int ch, input logic exp, input string req);
    n_run++;
    if (pfm_mode_o[ch] !== exp) begin
      n_fail++;
      $display("FAIL %s ch%0d: mode=%b expected=%b", req, ch, pfm_mode_o[ch], exp);
    end
  endtask

  // drive at negedge, clock once, leave at next negedge
  task automatic step(input int ch, input logic vld, input logic signed [SW-1:0] smp,
                      input logic ex);
    sample_vld_i[ch] = vld;
    sample_i[ch*SW +: SW] = smp;
    exit_req_i[ch] = ex;
    @(posedge clk_i);
    @(negedge clk_i);
    sample_vld_i[ch] = 1'b0;
    exit_req_i[ch] = 1'b0;
  endtask

  task automatic setup(input int ch, input logic signed [SW-1:0] thr, input int len);
    thresh_i[ch*SW +: SW] = thr;
    run_len_i[ch*CW +: CW] = CW'(len);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: mode=%b expected=done", pfm_mode_o);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    setup(0, 12'sd100, 3);
    setup(1, 12'sd100, 3);
    #23;
    check(0, 1'b0, "R1");
    check(1, 1'b0, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(0, 1'b0, "R1");

    foreach (VECS[i]) begin
      step(0, VECS[i].vld, VECS[i].smp, VECS[i].ex);
      check(0, VECS[i].exp, $sformatf("R2/R3/R5/R6/R9/R12 vec%0d", i));
    end

    // R2: run length 20
    setup(0, 12'sd100, 20);
    for (int k = 0; k < 19; k++) step(0, 1'b1, 12'sd5, 1'b0);
    check(0, 1'b0, "R2 19 of 20");
    step(0, 1'b1, 12'sd5, 1'b0);
    check(0, 1'b1, "R2 20 of 20");
    step(0, 1'b1, 12'sd200, 1'b0);
    check(0, 1'b0, "R5");

    // R4: signed compare with negative threshold
    setup(0, -12'sd5, 2);
    step(0, 1'b1, 12'sd3, 1'b0);
    step(0, 1'b1, 12'sd3, 1'b0);
    check(0, 1'b0, "R4 positive above negative thr");
    step(0, 1'b1, -12'sd6, 1'b0);
    step(0, 1'b1, -12'sd100, 1'b0);
    check(0, 1'b1, "R4 negative below thr");
    step(0, 1'b1, -12'sd5, 1'b0);
    check(0, 1'b0, "R4/R5 equal negative");

    // R7: forbid mid-run and in PFM
    setup(0, 12'sd100, 3);
    step(0, 1'b1, 12'sd1, 1'b0);
    step(0, 1'b1, 12'sd1, 1'b0);
    pfm_allow_i[0] = 1'b0;
    step(0, 1'b1, 12'sd1, 1'b0);
    check(0, 1'b0, "R7 forbidden");
    pfm_allow_i[0] = 1'b1;
    step(0, 1'b1, 12'sd1, 1'b0);
    step(0, 1'b1, 12'sd1, 1'b0);
    check(0, 1'b0, "R7 run cleared");
    step(0, 1'b1, 12'sd1, 1'b0);
    check(0, 1'b1, "R7 re-entry");
    pfm_allow_i[0] = 1'b0;
    step(0, 1'b0, 12'sd1, 1'b0);
    check(0, 1'b0, "R7 forbid leaves PFM");
    pfm_allow_i[0] = 1'b1;

    // R8: disable mid-run and in PFM
    step(0, 1'b1, 12'sd1, 1'b0);
    step(0, 1'b1, 12'sd1, 1'b0);
    chan_en_i[0] = 1'b0;
    step(0, 1'b0, 12'sd1, 1'b0);
    chan_en_i[0] = 1'b1;
    step(0, 1'b1, 12'sd1, 1'b0);
    step(0, 1'b1, 12'sd1, 1'b0);
    check(0, 1'b0, "R8 run cleared");
    step(0, 1'b1, 12'sd1, 1'b0);
    check(0, 1'b1, "R8 entry");
    chan_en_i[0] = 1'b0;
    step(0, 1'b1, 12'sd1, 1'b0);
    check(0, 1'b0, "R8 disabled");
    chan_en_i[0] = 1'b1;

    // R10: run length 0 and 1
    setup(0, 12'sd100, 0);
    step(0, 1'b1, 12'sd1, 1'b0);
    check(0, 1'b1, "R10 len0");
    step(0, 1'b1, 12'sd101, 1'b0);
    setup(0, 12'sd100, 1);
    step(0, 1'b1, 12'sd1, 1'b0);
    check(0, 1'b1, "R10 len1");

    // R11: channel 1 independent of channel 0
    step(1, 1'b1, 12'sd1, 1'b0);
    step(1, 1'b1, 12'sd1, 1'b0);
    check(1, 1'b0, "R11 ch1 mid-run");
    check(0, 1'b1, "R11 ch0 unaffected");
    step(1, 1'b1, 12'sd1, 1'b0);
    check(1, 1'b1, "R11 ch1 entry");
    step(0, 1'b0, 12'sd0, 1'b1);
    check(0, 1'b0, "R11 ch0 exit");
    check(1, 1'b1, "R11 ch1 unaffected");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule